// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in a single combinational pass, whether an instruction that reads or writes a control/status register may reach the 12-bit register address it names. It sees the address, the hart's current privilege level, whether the access writes, and the virtual-memory trap enable bit from the status register. It drives one flag: high when the access may proceed, low when the pipeline has to raise an illegal-instruction exception in its place.

The checker applies three tests, and all three must pass. First, the address has to be one of the registers the core implements, at a privilege level that can see it. Second, the access must respect the rules the address encoding carries: the top two bits mark registers that software cannot write, and the next two bits give the lowest privilege allowed to touch the register. Third, supervisor code may not reach the address-translation register while the trap-virtual-memory bit is set. The values of the registers themselves are handled elsewhere.

Top module: `csr_perm_check`

## Requirements
- R1: When address bits [11:10] are 2'b11, any access with `wr_en` high is reported illegal.
- R2: A read (`wr_en` low) of a register whose address bits [11:10] are 2'b11 is legal from Machine mode when the address is implemented (0xF11 to 0xF14).
- R3: An access is illegal when the privilege encoding (User=2'b00, Supervisor=2'b01, Machine=2'b11) is below address bits [9:8], compared unsigned.
- R4: Addresses 0xF11 to 0xF14, 0x300 to 0x306 and 0x340 to 0x344 are implemented only in Machine mode. Machine access within the other rules is legal, and access from any other mode is illegal.
- R5: Addresses 0x100, 0x102 to 0x106, 0x140 to 0x144 and 0x180 are implemented in Machine and Supervisor modes, and access to them from User mode is illegal.
- R6: Any address outside the lists in R4 and R5 (for example 0x101, 0x307, 0x345, 0xF10, 0xF15, 0x181) is illegal in every mode.
- R7: Access to 0x180 from Supervisor mode is illegal, for reads and writes alike, while `tvm` is high. Machine-mode access to 0x180 stays legal while `tvm` is high.
- R8: While `tvm` is low, Supervisor reads and writes of 0x180 are legal, and `tvm` has no effect on any address other than 0x180.
- R9: The reserved privilege encoding 2'b10 makes every access illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| csr_addr | input | 12 | Register address named by the instruction |
| cur_priv | input | 2 | Current privilege: 00 User, 01 Supervisor, 11 Machine |
| wr_en | input | 1 | High when the instruction writes the register |
| tvm | input | 1 | Trap-virtual-memory bit taken from the status register |
| access_ok | output | 1 | High when the access is legal; low means raise illegal-instruction |

## Verification
The bench probes the addresses on each side of every implemented range (0xF10/0xF15, 0x307, 0x345, 0x101, 0x145, 0x181). A decoder whose range limits are off by one would accept or reject those addresses wrongly. It pairs the translation register with every mode and both `tvm` values, so a trap that fires in Machine mode or also catches neighbouring addresses shows up. Writes to the read-only informational registers and accesses from the reserved privilege encoding are exercised as well. Either would slip through if the read-only test or the mode admission test were left out. Random addresses, half of them drawn from the implemented set, cover the combinations of the three tests.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;

  localparam int CSR_AW = 12;
  localparam int PRV_W  = 2;

  typedef enum logic [PRV_W-1:0] {
    PRV_USER  = 2'b00,
    PRV_SUPER = 2'b01,
    PRV_RSVD  = 2'b10,
    PRV_MACH  = 2'b11
  } prv_e;

  // One contiguous range of implemented addresses and who may see it.
  typedef struct packed {
    logic [CSR_AW-1:0] lo;
    logic [CSR_AW-1:0] hi;
    logic              mach_only;
  } csr_span_t;

  localparam int N_SPANS = 7;

  localparam csr_span_t SPAN_TABLE [N_SPANS] = '{
    '{12'hF11, 12'hF14, 1'b1},
    '{12'h300, 12'h306, 1'b1},
    '{12'h340, 12'h344, 1'b1},
    '{12'h100, 12'h100, 1'b0},
    '{12'h102, 12'h106, 1'b0},
    '{12'h140, 12'h144, 1'b0},
    '{12'h180, 12'h180, 1'b0}
  };

  localparam logic [CSR_AW-1:0] SATP_ADDR = 12'h180;

  // Encoding field: top two address bits all ones means no writes.
  function automatic logic is_ro_field(input logic [CSR_AW-1:0] a);
    return a[CSR_AW-1 -: 2] == 2'b11;
  endfunction

  // Encoding field: lowest privilege that may touch the register.
  function automatic logic [PRV_W-1:0] floor_field(input logic [CSR_AW-1:0] a);
    return a[CSR_AW-3 -: 2];
  endfunction

  function automatic logic priv_meets(input logic [PRV_W-1:0] cur,
                                      input logic [PRV_W-1:0] floor);
    return cur >= floor;
  endfunction

  function automatic logic in_span(input logic [CSR_AW-1:0] a,
                                   input csr_span_t s);
    return (a >= s.lo) && (a <= s.hi);
  endfunction

  function automatic logic mode_admits(input logic [PRV_W-1:0] cur,
                                       input logic mach_only);
    return (cur == PRV_MACH) || (!mach_only && (cur == PRV_SUPER));
  endfunction

endpackage

// File: rtl/csr_span_decode.sv
module csr_span_decode
  import csr_perm_pkg::*;
#(
  parameter int SPANS = N_SPANS
) (
  input  logic [CSR_AW-1:0] addr,
  input  logic [PRV_W-1:0]  cur_priv,
  output logic [SPANS-1:0]  span_hit,
  output logic              addr_known
);

  logic [SPANS-1:0] span_admit;

  for (genvar i = 0; i < SPANS; i++) begin : g_span
    assign span_hit[i]   = in_span(addr, SPAN_TABLE[i]);
    assign span_admit[i] = span_hit[i] && mode_admits(cur_priv, SPAN_TABLE[i].mach_only);
  end

  assign addr_known = |span_admit;

endmodule

// File: rtl/csr_field_rules.sv
module csr_field_rules
  import csr_perm_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  input  logic [PRV_W-1:0]  cur_priv,
  input  logic              wr_en,
  output logic              ro_ok,
  output logic              priv_ok,
  output logic              rules_ok
);

  assign ro_ok    = !(wr_en && is_ro_field(addr));
  assign priv_ok  = priv_meets(cur_priv, floor_field(addr));
  assign rules_ok = ro_ok && priv_ok;

endmodule

// File: rtl/csr_vm_trap.sv
module csr_vm_trap
  import csr_perm_pkg::*;
#(
  parameter logic [CSR_AW-1:0] TRAP_ADDR = SATP_ADDR
) (
  input  logic [CSR_AW-1:0] addr,
  input  logic [PRV_W-1:0]  cur_priv,
  input  logic              tvm,
  output logic              vm_ok
);

  logic hits_trap_reg;
  logic from_super;

  assign hits_trap_reg = (addr == TRAP_ADDR);
  assign from_super    = (cur_priv == PRV_SUPER);
  assign vm_ok         = !(hits_trap_reg && from_super && tvm);

endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
  import csr_perm_pkg::*;
(
  input  logic [11:0] csr_addr,
  input  logic [1:0]  cur_priv,
  input  logic        wr_en,
  input  logic        tvm,
  output logic        access_ok
);

  logic [N_SPANS-1:0] span_hit;
  logic               addr_known;
  logic               ro_ok;
  logic               priv_ok;
  logic               rules_ok;
  logic               vm_ok;

  csr_span_decode #(.SPANS(N_SPANS)) u_decode (
    .addr       (csr_addr),
    .cur_priv   (cur_priv),
    .span_hit   (span_hit),
    .addr_known (addr_known)
  );

  csr_field_rules u_rules (
    .addr     (csr_addr),
    .cur_priv (cur_priv),
    .wr_en    (wr_en),
    .ro_ok    (ro_ok),
    .priv_ok  (priv_ok),
    .rules_ok (rules_ok)
  );

  csr_vm_trap #(.TRAP_ADDR(SATP_ADDR)) u_vm (
    .addr     (csr_addr),
    .cur_priv (cur_priv),
    .tvm      (tvm),
    .vm_ok    (vm_ok)
  );

  assign access_ok = addr_known && rules_ok && vm_ok;

  always_comb begin
    AST_RO_WRITE_BLOCKED: assert (!(wr_en && csr_addr[11:10] == 2'b11) || !access_ok)
      else $error("write to read-only address accepted"); // R1
    AST_PRIV_FLOOR: assert (!(cur_priv < csr_addr[9:8]) || !access_ok)
      else $error("privilege below floor accepted"); // R3
    AST_UNKNOWN_ADDR: assert (addr_known || !access_ok)
      else $error("unimplemented address accepted"); // R6
    AST_TVM_TRAP: assert (!(csr_addr == 12'h180 && cur_priv == 2'b01 && tvm) || !access_ok)
      else $error("translation register reached under tvm"); // R7
    AST_RSVD_PRIV: assert (cur_priv != 2'b10 || !access_ok)
      else $error("reserved privilege accepted"); // R9
    AST_DECODE_ONE: assert ($onehot0(span_hit))
      else $error("address decoded into several ranges"); // R6
  end

endmodule

// File: tb/sim_csr_perm_check.sv
module sim_csr_perm_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  cur_priv = '0;
  logic        wr_en = 1'b0;
  logic        tvm = 1'b0;
  logic        access_ok;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  csr_perm_check u0 (
    .csr_addr  (csr_addr),
    .cur_priv  (cur_priv),
    .wr_en     (wr_en),
    .tvm       (tvm),
    .access_ok (access_ok)
  );

  // Independent model: implemented-address list (R4, R5, R6).
  function automatic bit m_known(input logic [11:0] a, input logic [1:0] p);
    case (a)
      12'hF11, 12'hF12, 12'hF13, 12'hF14,
      12'h300, 12'h301, 12'h302, 12'h303, 12'h304, 12'h305, 12'h306,
      12'h340, 12'h341, 12'h342, 12'h343, 12'h344: return p == 2'b11;
      12'h100, 12'h102, 12'h103, 12'h104, 12'h105, 12'h106,
      12'h140, 12'h141, 12'h142, 12'h143, 12'h144,
      12'h180: return (p == 2'b11) || (p == 2'b01);
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_legal(input logic [11:0] a, input logic [1:0] p,
                                 input bit w, input bit t);
    if (!m_known(a, p)) return 1'b0;
    if (w && a[11] && a[10]) return 1'b0;
    if ({1'b0, p} < {1'b0, a[9:8]}) return 1'b0;
    if (a == 12'h180 && p == 2'b01 && t) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string m_tag(input logic [11:0] a, input logic [1:0] p,
                                  input bit w, input bit t);
    if (p == 2'b10) return "R9";
    if (!m_known(a, p)) return "R6";
    if (w && a[11] && a[10]) return "R1";
    if (p < a[9:8]) return "R3";
    if (a == 12'h180) return t ? "R7" : "R8";
    return (a[9:8] == 2'b11) ? "R4" : "R5";
  endfunction

  function automatic logic [11:0] pick_known(input int unsigned idx);
    if (idx < 4)  return 12'hF11 + 12'(idx);
    if (idx < 11) return 12'h300 + 12'(idx - 4);
    if (idx < 16) return 12'h340 + 12'(idx - 11);
    if (idx == 16) return 12'h100;
    if (idx < 22) return 12'h102 + 12'(idx - 17);
    if (idx < 27) return 12'h140 + 12'(idx - 22);
    return 12'h180;
  endfunction

  task automatic chk(input logic [11:0] a, input logic [1:0] p, input bit w,
                     input bit t, input bit exp, input string tag);
    @(posedge clk);
    csr_addr = a; cur_priv = p; wr_en = w; tvm = t;
    #1;
    n_checks++;
    if (access_ok !== exp) begin
      n_fails++;
      $display("FAIL %s addr=%h priv=%b wr=%0b tvm=%0b actual=%0b expected=%0b",
               tag, a, p, w, t, access_ok, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // Reset-time inputs: address 0x000 from User is unimplemented (R6)
    n_checks++;
    if (access_ok !== 1'b0) begin
      n_fails++;
      $display("FAIL R6 reset actual=%0b expected=0", access_ok);
    end
    rst_n = 1'b1;

    // R2 / R1: read-only informational registers
    chk(12'hF11, 2'b11, 0, 0, 1, "R2");
    chk(12'hF14, 2'b11, 0, 1, 1, "R2");
    chk(12'hF14, 2'b11, 1, 0, 0, "R1");
    chk(12'hF12, 2'b11, 1, 0, 0, "R1");
    // R4: machine-only ranges
    chk(12'h300, 2'b11, 1, 0, 1, "R4");
    chk(12'h306, 2'b11, 1, 0, 1, "R4");
    chk(12'h344, 2'b11, 0, 0, 1, "R4");
    chk(12'h306, 2'b01, 0, 0, 0, "R4");
    chk(12'hF12, 2'b01, 0, 0, 0, "R4");
    // R6: neighbours of every range
    chk(12'h307, 2'b11, 0, 0, 0, "R6");
    chk(12'h345, 2'b11, 0, 0, 0, "R6");
    chk(12'hF10, 2'b11, 0, 0, 0, "R6");
    chk(12'hF15, 2'b11, 0, 0, 0, "R6");
    chk(12'h101, 2'b01, 0, 0, 0, "R6");
    chk(12'h145, 2'b01, 0, 0, 0, "R6");
    chk(12'h181, 2'b11, 0, 0, 0, "R6");
    chk(12'h33F, 2'b11, 0, 0, 0, "R6");
    // R5: supervisor ranges
    chk(12'h100, 2'b01, 1, 0, 1, "R5");
    chk(12'h106, 2'b01, 1, 1, 1, "R5");
    chk(12'h144, 2'b11, 1, 0, 1, "R5");
    chk(12'h100, 2'b00, 0, 0, 0, "R5");
    // R3: privilege floor
    chk(12'h104, 2'b00, 0, 0, 0, "R3");
    chk(12'h340, 2'b01, 0, 0, 0, "R3");
    // R7 / R8: translation register trap
    chk(12'h180, 2'b01, 0, 1, 0, "R7");
    chk(12'h180, 2'b01, 1, 1, 0, "R7");
    chk(12'h180, 2'b11, 1, 1, 1, "R7");
    chk(12'h180, 2'b01, 0, 0, 1, "R8");
    chk(12'h180, 2'b01, 1, 0, 1, "R8");
    chk(12'h140, 2'b01, 1, 1, 1, "R8");
    chk(12'h105, 2'b01, 1, 1, 1, "R8");
    // R9: reserved privilege
    chk(12'h300, 2'b10, 0, 0, 0, "R9");
    chk(12'h100, 2'b10, 0, 0, 0, "R9");
    chk(12'h180, 2'b10, 0, 0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [1:0]  p;
      bit w, t;
      if ($urandom_range(1, 0) == 1) a = pick_known($urandom_range(27, 0));
      else                           a = 12'($urandom);
      p = 2'($urandom);
      w = 1'($urandom);
      t = 1'($urandom);
      chk(a, p, w, t, m_legal(a, p, w, t), m_tag(a, p, w, t));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule